// File: doc/BRIEF.md
# Interrupt Flag and Enable Register

This block gathers interrupt events from seven on-chip sources (two timers, the shift register and the two control lines of each of two parallel ports) into a single active-low interrupt request. Each source owns one sticky flag bit. The flag is set by a one-cycle pulse from the source. It is cleared either by a one-cycle clear pulse from the same source or by a bus write to the flag register. An enable register masks the flags. The request is asserted while any flag is set whose enable is also set.

A byte-wide register port exposes two addresses. Address 0 is the flag register. Writing 1s to it clears flags. Reading it returns the flags, with a computed summary bit on top. Address 1 is the enable register. On a write, bit 7 selects whether the 1s in bits 6:0 set or clear enables. When read, bit 7 always returns 1. Reads have no side effects, and read data is combinational from the address.

Top module: `irq_flag_enable`

## Requirements
- R1: While `rst_ni` is low and after it rises, all flags and enables are 0: `irq_no` is 1, a read of address 0 returns 0x00 and a read of address 1 returns 0x80.
- R2: A 1 on `set_i[k]` at a clock edge sets flag k, and it stays set until cleared. The bit map is: 0 = port A line 2, 1 = port A line 1, 2 = shift register, 3 = port B line 2, 4 = port B line 1, 5 = timer 2, 6 = timer 1.
- R3: A 1 on `clr_i[k]` at a clock edge clears flag k. Other flags are unchanged.
- R4: A write (`wr_i`=1) to address 0 clears each flag whose `wdata_i` bit (6:0) is 1. Flags written with 0 are unchanged, and `wdata_i[7]` has no effect.
- R5: When `set_i[k]` and a clear of flag k (from `clr_i[k]` or an address-0 write) arrive at the same edge, flag k ends up set.
- R6: A write to address 1 with `wdata_i[7]`=1 sets each enable whose data bit (6:0) is 1. With `wdata_i[7]`=0 it clears each such enable. Enables written with 0 are unchanged.
- R7: With `addr_i`=0, `rdata_o[6:0]` shows the flags, and `rdata_o[7]` is 1 exactly when some flag and its enable are both 1.
- R8: With `addr_i`=1, `rdata_o[6:0]` shows the enables and `rdata_o[7]` is 1.
- R9: `irq_no` is 0 exactly when some flag and its enable are both 1. It follows the register state with no added cycle, so it falls right after the edge that sets an enabled flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 7 | Per-source flag set pulses |
| clr_i | input | 7 | Per-source flag clear pulses |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 flags, 1 enables |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the assertions check the following properties:
- set pulses take effect and win over clears;
- clear pulses and flag-register writes leave no targeted flag set unless that flag is also being set;
- an enable write moves exactly the masked bits in the chosen direction, and enables never move without a write;
- the enable read's top bit is 1;
- the request agrees with the flag-read summary bit.

Only the bench's scenarios show the exact value of every read across mixed sequences: partial masks, a flag write carrying only bit 7, flags pending behind disabled enables, and re-enabling a pending source that drops the request at once.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int unsigned NUM_SRC = 7;

  // Flag positions
  localparam int unsigned BIT_PA_L2 = 0;
  localparam int unsigned BIT_PA_L1 = 1;
  localparam int unsigned BIT_SHIFT = 2;
  localparam int unsigned BIT_PB_L2 = 3;
  localparam int unsigned BIT_PB_L1 = 4;
  localparam int unsigned BIT_TMR2  = 5;
  localparam int unsigned BIT_TMR1  = 6;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqfe_flag_cell.sv
module irqfe_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set has priority
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irqfe_flag_bank.sv
module irqfe_flag_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               bus_wr_i,
  input  logic [NUM_SRC-1:0] bus_mask_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] clr_any;

  assign clr_any = clr_i | (bus_mask_i & {NUM_SRC{bus_wr_i}});

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cell
    irqfe_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_i[k]),
      .clr_i  (clr_any[k]),
      .q_o    (flags_o[k])
    );
  end
endmodule

// File: rtl/irqfe_enable_bank.sv
module irqfe_enable_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               set_mode_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_d;

  always_comb begin
    en_d = en_o;
    if (wr_i) begin
      if (set_mode_i) en_d = en_o | mask_i;
      else            en_d = en_o & ~mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else         en_o <= en_d;
  end
endmodule

// File: rtl/irqfe_read_mux.sv
module irqfe_read_mux #(
  parameter int unsigned NUM_SRC = 7,
  localparam int unsigned DATA_W = NUM_SRC + 1
) (
  input  irqfe_pkg::reg_sel_e sel_i,
  input  logic [NUM_SRC-1:0]  flags_i,
  input  logic [NUM_SRC-1:0]  en_i,
  input  logic                pend_i,
  output logic [DATA_W-1:0]   rdata_o
);
  always_comb begin
    unique case (sel_i)
      irqfe_pkg::SEL_FLAG: rdata_o = {pend_i, flags_i};
      default:             rdata_o = {1'b1, en_i};
    endcase
  end
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable #(
  parameter int unsigned NUM_SRC = irqfe_pkg::NUM_SRC,
  localparam int unsigned DATA_W = NUM_SRC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_no
);
  irqfe_pkg::reg_sel_e sel;
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] en_q;
  logic               flag_wr;
  logic               en_wr;
  logic               pend;

  assign sel     = irqfe_pkg::reg_sel_e'(addr_i);
  assign flag_wr = wr_i && (sel == irqfe_pkg::SEL_FLAG);
  assign en_wr   = wr_i && (sel == irqfe_pkg::SEL_EN);
  assign pend    = |(flags_q & en_q);
  assign irq_no  = ~pend;

  irqfe_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .bus_wr_i   (flag_wr),
    .bus_mask_i (wdata_i[NUM_SRC-1:0]),
    .flags_o    (flags_q)
  );

  irqfe_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (en_wr),
    .set_mode_i (wdata_i[NUM_SRC]),
    .mask_i     (wdata_i[NUM_SRC-1:0]),
    .en_o       (en_q)
  );

  irqfe_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .sel_i   (sel),
    .flags_i (flags_q),
    .en_i    (en_q),
    .pend_i  (pend),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irqfe_chk.sv
module irqfe_chk #(
  parameter int unsigned NUM_SRC = 7,
  localparam int unsigned DATA_W = NUM_SRC + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] set_i,
  input logic [NUM_SRC-1:0] clr_i,
  input logic               wr_i,
  input logic               addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_no,
  input logic [NUM_SRC-1:0] flags_q,
  input logic [NUM_SRC-1:0] en_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (flags_q == '0 && en_q == '0 && irq_no));

  // R2 R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R3
  src_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  // R4
  bus_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> ((flags_q & $past(wdata_i[NUM_SRC-1:0] & ~set_i)) == '0));

  // R6
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && wdata_i[NUM_SRC])
      |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && !wdata_i[NUM_SRC])
      |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  // R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i) |=> $stable(en_q));

  // R8
  en_read_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> rdata_o[NUM_SRC]);

  // R7 R9
  irq_summary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> (rdata_o[NUM_SRC] == !irq_no));
endmodule

bind irq_flag_enable irqfe_chk #(.NUM_SRC(NUM_SRC)) u_irqfe_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .set_i   (set_i),
  .clr_i   (clr_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .flags_q (flags_q),
  .en_q    (en_q)
);

// File: tb/irq_flag_enable_bench.sv
`timescale 1ns/1ps
module irq_flag_enable_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] set_s = '0;
  logic [6:0] clr_s = '0;
  logic       wr = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  bit [6:0] m_flags = '0;
  bit [6:0] m_en    = '0;

  always #2.5 clk = ~clk;

  irq_flag_enable u_irq_flag_enable (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .set_i   (set_s),
    .clr_i   (clr_s),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wd),
    .rdata_o (rdata),
    .irq_no  (irq_n)
  );

  function automatic bit [7:0] exp_rd(bit a);
    bit any = (m_flags & m_en) != 0;
    return a ? {1'b1, m_en} : {any, m_flags};
  endfunction

  task automatic compare(string tag);
    bit [7:0] er = exp_rd(addr);
    bit       ei = !((m_flags & m_en) != 0);
    vectors++;
    if (rdata !== er || irq_n !== ei) begin
      errors++;
      $display("FAIL %s rdata=%h exp=%h irq_no=%b exp=%b", tag, rdata, er, irq_n, ei);
    end
  endtask

  // drive one cycle, compare pre-edge outputs, then advance the model
  task automatic step(string tag, bit [6:0] s, bit [6:0] c, bit w, bit a, bit [7:0] d);
    @(negedge clk);
    set_s = s; clr_s = c; wr = w; addr = a; wd = d;
    #1 compare(tag);
    @(posedge clk);
    if (rst_n) begin
      if (w && !a) m_flags = m_flags & ~d[6:0];
      m_flags = (m_flags & ~c) | s;
      if (w && a) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    end
  endtask

  task automatic rd(string tag, bit a);
    step(tag, '0, '0, 1'b0, a, 8'h00);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: state during reset, with stimulus that must be ignored
    step("R1", 7'h7f, '0, 1'b1, 1'b1, 8'hff);
    step("R1", '0, '0, 1'b0, 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd("R1", 1'b0);
    rd("R1", 1'b1);

    // R2: each source alone, enables off
    for (int k = 0; k < 7; k++) begin
      step("R2", 7'(1 << k), '0, 1'b0, 1'b0, 8'h00);
      rd("R2", 1'b0);
    end
    rd("R7", 1'b0);                    // flags set, none enabled
    rd("R9", 1'b1);

    // R6/R8: enable set and clear
    step("R6", '0, '0, 1'b1, 1'b1, 8'h80 | 8'h24);
    rd("R8", 1'b1);
    rd("R9", 1'b0);
    step("R6", '0, '0, 1'b1, 1'b1, 8'h04);   // clear bit 2 only
    rd("R8", 1'b1);
    step("R6", '0, '0, 1'b1, 1'b1, 8'h00);   // clear-mode, empty mask
    rd("R6", 1'b1);
    step("R6", '0, '0, 1'b1, 1'b1, 8'hff);
    rd("R8", 1'b1);

    // R4: bus clear with partial mask, then bit7 only
    step("R4", '0, '0, 1'b1, 1'b0, 8'h05);
    rd("R4", 1'b0);
    step("R4", '0, '0, 1'b1, 1'b0, 8'h80);
    rd("R4", 1'b0);
    step("R4", '0, '0, 1'b1, 1'b0, 8'h7f);
    rd("R7", 1'b0);
    rd("R9", 1'b1);

    // R3: source clears
    step("R3", 7'h60, '0, 1'b0, 1'b0, 8'h00);
    step("R3", '0, 7'h20, 1'b0, 1'b0, 8'h00);
    rd("R3", 1'b0);
    step("R3", '0, 7'h40, 1'b0, 1'b0, 8'h00);
    rd("R3", 1'b0);

    // R5: set collides with clears
    step("R5", 7'h11, 7'h01, 1'b0, 1'b0, 8'h00);
    rd("R5", 1'b0);
    step("R5", 7'h02, '0, 1'b1, 1'b0, 8'h13);
    rd("R5", 1'b0);
    step("R5", 7'h08, 7'h08, 1'b1, 1'b0, 8'h08);
    rd("R5", 1'b0);

    // R9: pending flag behind disabled enable, then re-enabled
    step("R9", '0, '0, 1'b1, 1'b1, 8'h7f);
    rd("R9", 1'b0);
    step("R9", '0, '0, 1'b1, 1'b1, 8'h88);
    rd("R9", 1'b0);
    rd("R9", 1'b1);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    m_flags = '0; m_en = '0;
    rd("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    rd("R1", 1'b1);
    rd("R1", 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule